// File: doc/BRIEF.md
# Processor Control Register Unit

This block keeps the mode and address-translation control state of a small 32-bit processor model. It has three registers: a mode word, a fault-address register and a page-directory base. It takes register reads and writes through a request stream, task-switch events that bring in a new directory frame, and page-fault reports. It drives the current protection and paging enables and a one-cycle translation-cache flush pulse.

The block also sorts each issued floating-point or WAIT instruction into one of three classes: run on the coprocessor, hand to software emulation, or raise a device-not-available trap. The class follows from three bits of the mode word. An illegal register write raises a general-protection fault and changes nothing. An access to the unimplemented register slot raises an invalid-opcode fault.

The request stream uses valid/ready. A request moves when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low in any cycle where a task switch is presented, and high in every other cycle. A requester that sees ready low holds its request unchanged and retries. Read responses, faults, flushes and classifications come out as one-cycle pulses with no back-pressure.

Top module: `ctlreg_unit`

## Requirements
- R1: While reset is held, and after it is released with no other stimulus, these outputs are low: protection enable, paging enable, flush, both faults, response valid and class valid. Reads then return zero for the fault address and the directory base. The mode word reads back with only bit 4 set to the value of `cop_new_i`.
- R2: A mode-word write is illegal when it has bit 31 set with bit 0 clear, or when any of bits 30..5 is nonzero. It raises `gp_fault_o` one cycle after acceptance and leaves the mode word unchanged.
- R3: A legal mode-word write stores its fields one cycle after acceptance. The layout is: bit 0 protection enable, bit 1 coprocessor monitor, bit 2 emulate, bit 3 task-switched, bit 4 coprocessor kind, bit 31 paging enable. A read returns these fields at those positions, with every other bit zero.
- R4: `req_sel_i` selects the register: 0 is the mode word, 1 is unimplemented, 2 is the fault address and 3 is the directory base. Any access with select 1 raises `ud_fault_o` one cycle later, gives no response and changes no state.
- R5: A read accepted at a clock edge gives `rsp_valid_o` high with the register's value before that edge, one cycle later.
- R6: A directory-base write with any of bits 11..0 nonzero raises `gp_fault_o`, keeps the old base and gives no flush. A legal write, in any mode and even with an unchanged value, stores bits 31..12 and pulses `flush_o` one cycle later. Bits 11..0 always read as zero.
- R7: A task switch sets the task-switched bit and loads `task_frame_i` as bits 31..12 of the directory base. It pulses `flush_o` only if the frame differs from the stored one. While it is presented, `req_ready_o` is low and no request is accepted.
- R8: A page-fault report stores `pf_addr_i` into the fault address one cycle later. It takes priority over a fault-address write accepted in the same cycle, which is then lost.
- R9: A floating-point instruction (`ins_wait_i`=0) gives class 2 (trap) when task-switched is 1. Otherwise it gives class 1 (emulate) when emulate is 1, and class 0 (execute) in all other cases. The class is judged on the mode word before the issuing edge and appears one cycle later with `cls_valid_o`.
- R10: A WAIT instruction (`ins_wait_i`=1) gives class 2 only when both monitor and task-switched are 1, and class 0 otherwise, whatever the emulate bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_new_i | input | 1 | Coprocessor-kind strap, loaded into mode bit 4 at reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_sel_i | input | 2 | Register select |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid pulse |
| rsp_data_o | output | 32 | Read response data |
| task_valid_i | input | 1 | Task-switch event |
| task_frame_i | input | 20 | New directory frame (address bits 31..12) |
| pf_valid_i | input | 1 | Page-fault report |
| pf_addr_i | input | 32 | Faulting linear address |
| ins_valid_i | input | 1 | Coprocessor-class instruction issued |
| ins_wait_i | input | 1 | 1 = WAIT, 0 = floating-point operation |
| cls_valid_o | output | 1 | Classification valid pulse |
| cls_code_o | output | 2 | 0 execute, 1 emulate, 2 device-not-available |
| prot_en_o | output | 1 | Protection enable (mode bit 0) |
| page_en_o | output | 1 | Paging enable (mode bit 31) |
| flush_o | output | 1 | Translation-cache flush pulse |
| gp_fault_o | output | 1 | General-protection fault pulse |
| ud_fault_o | output | 1 | Invalid-opcode fault pulse |

## Verification
Every result of this block is due exactly one clock after the edge that accepts its stimulus. This covers register updates, the enable outputs, response data, fault and flush pulses, and classifications. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares every output at the next falling edge, so each pulse is checked in the one cycle where it must be high and checked low in every other cycle. `req_ready_o` is combinational from the task-switch input, so it is compared at that same falling edge while the inputs are still held.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int MW_W     = 32;
  localparam int BIT_PROT = 0;
  localparam int BIT_MON  = 1;
  localparam int BIT_EMU  = 2;
  localparam int BIT_TSW  = 3;
  localparam int BIT_KIND = 4;
  localparam int BIT_PAGE = 31;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_NONE  = 2'd1,
    SEL_FADDR = 2'd2,
    SEL_DIR   = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    CLS_EXEC  = 2'd0,
    CLS_EMUL  = 2'd1,
    CLS_NODEV = 2'd2
  } cls_e;

  typedef struct packed {
    logic page_en;
    logic cop_kind;
    logic task_sw;
    logic cop_emu;
    logic cop_mon;
    logic prot_en;
  } mode_t;
endpackage

// File: rtl/ctlreg_mode.sv
module ctlreg_mode
  import ctlreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cop_new_i,
  input  logic            wr_i,
  input  logic [MW_W-1:0] wdata_i,
  input  logic            task_evt_i,
  output mode_t           mode_o,
  output logic [MW_W-1:0] word_o,
  output logic            bad_o
);
  logic combo_bad;
  logic rsvd_bad;
  logic illegal;

  assign combo_bad = wdata_i[BIT_PAGE] & ~wdata_i[BIT_PROT];
  assign rsvd_bad  = |wdata_i[BIT_PAGE-1:BIT_KIND+1];
  assign illegal   = combo_bad | rsvd_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o.page_en  <= 1'b0;
      mode_o.cop_kind <= cop_new_i;
      mode_o.task_sw  <= 1'b0;
      mode_o.cop_emu  <= 1'b0;
      mode_o.cop_mon  <= 1'b0;
      mode_o.prot_en  <= 1'b0;
      bad_o           <= 1'b0;
    end else begin
      bad_o <= wr_i & illegal;
      if (wr_i && !illegal) begin
        mode_o.page_en  <= wdata_i[BIT_PAGE];
        mode_o.cop_kind <= wdata_i[BIT_KIND];
        mode_o.task_sw  <= wdata_i[BIT_TSW];
        mode_o.cop_emu  <= wdata_i[BIT_EMU];
        mode_o.cop_mon  <= wdata_i[BIT_MON];
        mode_o.prot_en  <= wdata_i[BIT_PROT];
      end
      if (task_evt_i) mode_o.task_sw <= 1'b1;
    end
  end

  always_comb begin
    word_o           = '0;
    word_o[BIT_PAGE] = mode_o.page_en;
    word_o[BIT_KIND] = mode_o.cop_kind;
    word_o[BIT_TSW]  = mode_o.task_sw;
    word_o[BIT_EMU]  = mode_o.cop_emu;
    word_o[BIT_MON]  = mode_o.cop_mon;
    word_o[BIT_PROT] = mode_o.prot_en;
  end

  AST_NO_PAGE_IN_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_o.page_en && !mode_o.prot_en)); // R2
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && illegal && !task_evt_i) |=> ($stable(mode_o) && bad_o)); // R2
  AST_TASK_SETS_TSW: assert property (@(posedge clk) disable iff (!rst_n)
    task_evt_i |=> mode_o.task_sw); // R7
endmodule

// File: rtl/ctlreg_xlat.sv
module ctlreg_xlat #(
  parameter int AW = 32,
  parameter int PS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_dir_i,
  input  logic            wr_fa_i,
  input  logic [AW-1:0]   wdata_i,
  input  logic            task_evt_i,
  input  logic [AW-PS-1:0] task_frame_i,
  input  logic            pf_i,
  input  logic [AW-1:0]   pf_addr_i,
  output logic [AW-1:0]   dir_o,
  output logic [AW-1:0]   faddr_o,
  output logic            flush_o,
  output logic            bad_o
);
  localparam int BW = AW - PS;

  logic [BW-1:0] dir_q;
  logic          low_bad;
  logic          dir_ok;
  logic          frame_new;

  assign low_bad   = |wdata_i[PS-1:0];
  assign dir_ok    = wr_dir_i & ~low_bad;
  assign frame_new = task_frame_i != dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      faddr_o <= '0;
      flush_o <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      flush_o <= dir_ok | (task_evt_i & frame_new);
      bad_o   <= wr_dir_i & low_bad;
      if (task_evt_i)  dir_q <= task_frame_i;
      else if (dir_ok) dir_q <= wdata_i[AW-1:PS];
      if (pf_i)         faddr_o <= pf_addr_i;
      else if (wr_fa_i) faddr_o <= wdata_i;
    end
  end

  assign dir_o = {dir_q, {PS{1'b0}}};

  AST_SAME_FRAME_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (task_evt_i && !frame_new && !wr_dir_i) |=> !flush_o); // R7
  AST_DIR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir_i && low_bad && !task_evt_i) |=> (!flush_o && bad_o && $stable(dir_o))); // R6
  AST_PF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_i |=> (faddr_o == $past(pf_addr_i))); // R8
endmodule

// File: rtl/ctlreg_fpclass.sv
module ctlreg_fpclass
  import ctlreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ins_valid_i,
  input  logic ins_wait_i,
  input  logic mon_i,
  input  logic emu_i,
  input  logic tsw_i,
  output logic cls_valid_o,
  output cls_e cls_code_o
);
  cls_e cls_d;

  always_comb begin
    if (ins_wait_i)  cls_d = (mon_i && tsw_i) ? CLS_NODEV : CLS_EXEC;
    else if (tsw_i)  cls_d = CLS_NODEV;
    else if (emu_i)  cls_d = CLS_EMUL;
    else             cls_d = CLS_EXEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_valid_o <= 1'b0;
      cls_code_o  <= CLS_EXEC;
    end else begin
      cls_valid_o <= ins_valid_i;
      if (ins_valid_i) cls_code_o <= cls_d;
    end
  end

  AST_FP_TASK_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && !ins_wait_i && tsw_i) |=> (cls_valid_o && cls_code_o == CLS_NODEV)); // R9
  AST_WAIT_NO_MON: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid_i && ins_wait_i && !mon_i) |=> (cls_code_o == CLS_EXEC)); // R10
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
  import ctlreg_pkg::*;
#(
  parameter int AW = 32,
  parameter int PS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cop_new_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [1:0]       req_sel_i,
  input  logic [AW-1:0]    req_wdata_i,
  output logic             rsp_valid_o,
  output logic [AW-1:0]    rsp_data_o,
  input  logic             task_valid_i,
  input  logic [AW-PS-1:0] task_frame_i,
  input  logic             pf_valid_i,
  input  logic [AW-1:0]    pf_addr_i,
  input  logic             ins_valid_i,
  input  logic             ins_wait_i,
  output logic             cls_valid_o,
  output logic [1:0]       cls_code_o,
  output logic             prot_en_o,
  output logic             page_en_o,
  output logic             flush_o,
  output logic             gp_fault_o,
  output logic             ud_fault_o
);
  sel_e            sel;
  logic            accept;
  logic            wr_mode, wr_fa, wr_dir, rd;
  mode_t           mode;
  logic [MW_W-1:0] mode_word;
  logic            mode_bad, dir_bad;
  logic [AW-1:0]   dir_val, fa_val;
  logic [AW-1:0]   rd_mux;
  cls_e            cls_code;

  assign sel         = sel_e'(req_sel_i);
  assign req_ready_o = ~task_valid_i;
  assign accept      = req_valid_i & req_ready_o;
  assign wr_mode     = accept & req_write_i & (sel == SEL_MODE);
  assign wr_fa       = accept & req_write_i & (sel == SEL_FADDR);
  assign wr_dir      = accept & req_write_i & (sel == SEL_DIR);
  assign rd          = accept & ~req_write_i & (sel != SEL_NONE);

  ctlreg_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .cop_new_i  (cop_new_i),
    .wr_i       (wr_mode),
    .wdata_i    (req_wdata_i[MW_W-1:0]),
    .task_evt_i (task_valid_i),
    .mode_o     (mode),
    .word_o     (mode_word),
    .bad_o      (mode_bad)
  );

  ctlreg_xlat #(.AW(AW), .PS(PS)) u_xlat (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_dir_i     (wr_dir),
    .wr_fa_i      (wr_fa),
    .wdata_i      (req_wdata_i),
    .task_evt_i   (task_valid_i),
    .task_frame_i (task_frame_i),
    .pf_i         (pf_valid_i),
    .pf_addr_i    (pf_addr_i),
    .dir_o        (dir_val),
    .faddr_o      (fa_val),
    .flush_o      (flush_o),
    .bad_o        (dir_bad)
  );

  ctlreg_fpclass u_fpclass (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid_i (ins_valid_i),
    .ins_wait_i  (ins_wait_i),
    .mon_i       (mode.cop_mon),
    .emu_i       (mode.cop_emu),
    .tsw_i       (mode.task_sw),
    .cls_valid_o (cls_valid_o),
    .cls_code_o  (cls_code)
  );

  always_comb begin
    case (sel)
      SEL_MODE:  rd_mux = AW'(mode_word);
      SEL_FADDR: rd_mux = fa_val;
      SEL_DIR:   rd_mux = dir_val;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      ud_fault_o  <= 1'b0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_data_o <= rd_mux;
      ud_fault_o <= accept & (sel == SEL_NONE);
    end
  end

  assign cls_code_o = cls_code;
  assign gp_fault_o = mode_bad | dir_bad;
  assign prot_en_o  = mode.prot_en;
  assign page_en_o  = mode.page_en;

  AST_ONE_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gp_fault_o, ud_fault_o, rsp_valid_o})); // R4
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !task_valid_i && !req_write_i && req_sel_i != 2'd1) |=> rsp_valid_o); // R5
  AST_NO_ACCEPT_ON_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    (task_valid_i && req_valid_i) |=> (!ud_fault_o && !rsp_valid_o)); // R7
endmodule

// File: tb/ctlreg_unit_tb.sv
module ctlreg_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cop_new = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        task_valid = 1'b0;
  logic [19:0] task_frame = '0;
  logic        pf_valid = 1'b0;
  logic [31:0] pf_addr = '0;
  logic        ins_valid = 1'b0, ins_wait = 1'b0;
  logic        req_ready, rsp_valid, cls_valid, prot_en, page_en, flush, gp_fault, ud_fault;
  logic [31:0] rsp_data;
  logic [1:0]  cls_code;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural model state
  logic        m_pe, m_pg, m_mp, m_em, m_ts, m_et;
  logic [31:0] m_dir, m_fa;
  logic        e_gp, e_ud, e_fl, e_rv, e_cv;
  logic [31:0] e_rd;
  logic [1:0]  e_cc;

  always #4 clk = ~clk;

  ctlreg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cop_new_i(cop_new),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_sel_i(req_sel), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .task_valid_i(task_valid), .task_frame_i(task_frame),
    .pf_valid_i(pf_valid), .pf_addr_i(pf_addr),
    .ins_valid_i(ins_valid), .ins_wait_i(ins_wait),
    .cls_valid_o(cls_valid), .cls_code_o(cls_code),
    .prot_en_o(prot_en), .page_en_o(page_en), .flush_o(flush),
    .gp_fault_o(gp_fault), .ud_fault_o(ud_fault)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pe = 0; m_pg = 0; m_mp = 0; m_em = 0; m_ts = 0; m_et = cop_new;
    m_dir = '0; m_fa = '0;
    e_gp = 0; e_ud = 0; e_fl = 0; e_rv = 0; e_cv = 0; e_rd = '0; e_cc = 2'd0;
  endtask

  function automatic logic [31:0] mode_word();
    return {m_pg, 26'd0, m_et, m_ts, m_em, m_mp, m_pe};
  endfunction

  task automatic model_step();
    logic acc;
    logic bad;
    e_gp = 0; e_ud = 0; e_fl = 0; e_rv = 0; e_cv = 0;
    acc = req_valid && !task_valid;
    if (ins_valid) begin
      e_cv = 1;
      if (ins_wait) e_cc = (m_mp && m_ts) ? 2'd2 : 2'd0;
      else          e_cc = m_ts ? 2'd2 : (m_em ? 2'd1 : 2'd0);
    end
    if (acc) begin
      case (req_sel)
        2'd0: if (req_write) begin
                bad = (req_wdata[31] && !req_wdata[0]) || (req_wdata[30:5] != 0);
                if (bad) e_gp = 1;
                else begin
                  m_pg = req_wdata[31]; m_et = req_wdata[4]; m_ts = req_wdata[3];
                  m_em = req_wdata[2];  m_mp = req_wdata[1]; m_pe = req_wdata[0];
                end
              end else begin e_rv = 1; e_rd = mode_word(); end
        2'd1: e_ud = 1;
        2'd2: if (req_write) begin if (!pf_valid) m_fa = req_wdata; end
              else begin e_rv = 1; e_rd = m_fa; end
        default: if (req_write) begin
                   if (req_wdata[11:0] != 0) e_gp = 1;
                   else begin m_dir = req_wdata; e_fl = 1; end
                 end else begin e_rv = 1; e_rd = m_dir; end
      endcase
    end
    if (task_valid) begin
      m_ts = 1;
      if (task_frame != m_dir[31:12]) e_fl = 1;
      m_dir = {task_frame, 12'd0};
    end
    if (pf_valid) m_fa = pf_addr;
  endtask

  task automatic compare(string tag);
    chk(tag, "req_ready", {31'd0, req_ready}, {31'd0, !task_valid});
    chk(tag, "prot_en", {31'd0, prot_en}, {31'd0, m_pe});
    chk(tag, "page_en", {31'd0, page_en}, {31'd0, m_pg});
    chk(tag, "flush", {31'd0, flush}, {31'd0, e_fl});
    chk(tag, "gp_fault", {31'd0, gp_fault}, {31'd0, e_gp});
    chk(tag, "ud_fault", {31'd0, ud_fault}, {31'd0, e_ud});
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
    if (e_rv) chk(tag, "rsp_data", rsp_data, e_rd);
    chk(tag, "cls_valid", {31'd0, cls_valid}, {31'd0, e_cv});
    if (e_cv) chk(tag, "cls_code", {30'd0, cls_code}, {30'd0, e_cc});
  endtask

  // one cycle: inputs already driven at a falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    req_valid = 0; req_write = 0; task_valid = 0; pf_valid = 0; ins_valid = 0;
  endtask

  task automatic wr(string tag, logic [1:0] s, logic [31:0] d);
    req_valid = 1; req_write = 1; req_sel = s; req_wdata = d; cyc(tag);
  endtask

  task automatic rdreg(string tag, logic [1:0] s);
    req_valid = 1; req_write = 0; req_sel = s; cyc(tag);
  endtask

  task automatic issue(string tag, logic w);
    ins_valid = 1; ins_wait = w; cyc(tag);
  endtask

  task automatic tswitch(string tag, logic [19:0] f);
    task_valid = 1; task_frame = f; cyc(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    cyc("R1 idle");
    cyc("R1 idle");
    rdreg("R1 mode", 2'd0);
    rdreg("R1 faddr", 2'd2);
    rdreg("R1 dir", 2'd3);

    // R6: directory base writable in real mode; bad low bits rejected
    wr("R6 real-mode dir", 2'd3, 32'h0040_0000);
    wr("R6 low bits", 2'd3, 32'h1234_5001);
    rdreg("R6 dir kept", 2'd3);
    wr("R6 legal", 2'd3, 32'h1234_5000);
    wr("R6 same value", 2'd3, 32'h1234_5000);
    rdreg("R6 readback", 2'd3);

    // R2: illegal mode writes
    wr("R2 page w/o prot", 2'd0, 32'h8000_0000);
    wr("R2 reserved bit", 2'd0, 32'h0000_0021);
    wr("R2 reserved bit 30", 2'd0, 32'h4000_0001);
    rdreg("R2 unchanged", 2'd0);

    // R3: legal writes and layout
    wr("R3 prot", 2'd0, 32'h0000_0001);
    wr("R3 paging", 2'd0, 32'h8000_0013);
    rdreg("R3 read", 2'd0);
    wr("R3 kind clear", 2'd0, 32'h8000_0001);
    rdreg("R3 read2", 2'd0);

    // R4: unimplemented slot
    rdreg("R4 read slot1", 2'd1);
    wr("R4 write slot1", 2'd1, 32'hFFFF_FFFF);
    rdreg("R4 mode intact", 2'd0);

    // R9/R10 classification
    issue("R9 exec", 1'b0);
    issue("R10 wait exec", 1'b1);
    wr("R9 emu on", 2'd0, 32'h8000_0005);
    issue("R9 emulate", 1'b0);
    issue("R10 wait ignores emu", 1'b1);
    wr("R9 emu+ts", 2'd0, 32'h8000_000D);
    issue("R9 trap over emulate", 1'b0);
    issue("R10 wait mon=0", 1'b1);
    wr("R10 mon+ts", 2'd0, 32'h8000_000B);
    issue("R10 wait trap", 1'b1);
    issue("R9 fp trap", 1'b0);
    ins_valid = 1; ins_wait = 1'b0;
    req_valid = 1; req_write = 1; req_sel = 2'd0; req_wdata = 32'h8000_0001;
    cyc("R9 judged on old mode");
    issue("R9 after clear", 1'b0);

    // R7: task switch
    tswitch("R7 same frame", 20'h12345);
    rdreg("R7 tsw set", 2'd0);
    task_valid = 1; task_frame = 20'h00020; req_valid = 1; req_write = 0; req_sel = 2'd1;
    cyc("R7 new frame blocks req");
    rdreg("R7 dir", 2'd3);
    tswitch("R7 same again", 20'h00020);

    // R8 / R5: fault address
    pf_valid = 1; pf_addr = 32'hDEAD_BEEF; cyc("R8 capture");
    rdreg("R5 faddr", 2'd2);
    pf_valid = 1; pf_addr = 32'h0BAD_F00D;
    req_valid = 1; req_write = 1; req_sel = 2'd2; req_wdata = 32'h1111_2222;
    cyc("R8 priority");
    rdreg("R8 read", 2'd2);
    wr("R5 write faddr", 2'd2, 32'h5555_AAAA);
    pf_valid = 1; pf_addr = 32'h7777_0000;
    req_valid = 1; req_write = 0; req_sel = 2'd2;
    cyc("R5 read old value");
    rdreg("R5 read new", 2'd2);
    cyc("R1 final idle");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule